// File: doc/BRIEF.md
# Command Issue and Response Capture

This block sits between the register interface of a memory-card host and its card-side command engine. Software loads a 6-bit command index, a 32-bit argument written as two 16-bit halves, and a command configuration word. The block then starts the command, either at the configuration write when the card clock is running or later when the clock is started with a command still pending. It presents the index and argument on a card port with a request/done handshake. The card side answers with a byte count and up to 16 response bytes.

The block checks the returned byte count against the 2-bit response type held in the configuration word. A good reply is packed into a nine-word halfword store. A reply that is too short raises a response-timeout status instead. After a good reply the block decides whether a data phase follows, and in which direction. Every completed command gives a one-cycle end-of-command request. Software drains the response one halfword per pop.

Top module: `cmdrsp_top`

## Requirements
- R1: After reset, clock status, timeout status, response-end status, card request, data-phase flag and end-of-command pulse are all 0. The response word reads 0, the index readback reads 7'h40 and the argument readback reads 0.
- R2: A write goes to the register chosen by `wr_sel`: 0 clock control, 1 configuration, 2 command index, 3 argument high half, 4 argument low half. Each argument write replaces only its own 16 bits. The index reads back with bit 6 forced to 1. Index and argument appear unchanged on `card_idx` and `card_arg`.
- R3: A configuration write stores data bits 13:10 and 8:0. Bit 9 and bits 15:14 read back as 0. The write marks a command pending and clears the data-phase flag. It starts the command at once only when data bit 10 (stop-transfer) is 0 and clock status is 1.
- R4: A clock-control write with data bit 1 set and bit 0 clear sets clock status. It starts a pending command unless stored configuration bit 10 is 1. Data bit 0 clears clock status and the data-phase flag, and takes priority over bit 1.
- R5: `card_req` rises in the cycle after a start, stays high until `card_done` is sampled, and falls in the next cycle. The start clears the pending mark.
- R6: Configuration bits 1:0 select the response type. Type 0 needs 0 bytes, types 1 and 3 need at least 4, and type 2 needs at least 16. A shorter reply sets timeout status and gives no data phase.
- R7: A reply that is long enough sets response-end status. It sets the data-phase flag to configuration bit 2. `data_write` follows configuration bit 3 (1 write, 0 read).
- R8: `eoc_pulse` is high for exactly the one cycle after each completion, whether the reply is good or short.
- R9: After a good reply, response word i holds byte 2i in bits 7:0 and byte 2i+1 in bits 15:8, where byte k is `card_bytes[8k+7:8k]`. Bytes at an index equal to or above `card_len` read as 0.
- R10: Each start clears all nine response words and the read position. Each pop advances to the next word. After nine pops `rsp_word` reads 0.
- R11: Each start clears timeout and response-end status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 16 | Write data |
| idx_rb | output | 7 | Command index readback, bit 6 forced high |
| arg_rb | output | 32 | Argument readback |
| cfg_rb | output | 14 | Stored configuration word |
| rsp_pop | input | 1 | Advance to the next response word |
| rsp_word | output | 16 | Current response word |
| card_req | output | 1 | Command request to card side |
| card_idx | output | 6 | Command index to card side |
| card_arg | output | 32 | Command argument to card side |
| card_done | input | 1 | Card side has answered |
| card_len | input | 5 | Number of valid reply bytes (0 to 16) |
| card_bytes | input | 128 | Reply bytes, byte k in bits 8k+7:8k |
| stat_clk_en | output | 1 | Clock-enabled status |
| stat_tout | output | 1 | Response-timeout status |
| stat_rsp_end | output | 1 | Response-received status |
| eoc_pulse | output | 1 | End-of-command request, one cycle |
| data_active | output | 1 | Data phase granted |
| data_write | output | 1 | Data phase direction, 1 is write |

## Verification
The hardest case is a deferred start. A command is configured while the clock is stopped, or with stop-transfer set, and the clock start must later launch it, or must not. The bench reaches it by stopping the clock with both control bits set and then writing the configuration. It checks that no request appears, and then that a plain clock start raises one. Before that start, the status bits are still set from the previous command, so the start can be seen clearing them. A table of response types against byte counts on both sides of each threshold covers the timeout rule. The reply bytes beyond the count are made nonzero, so the masking in R9 can be seen.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

  typedef enum logic [2:0] {
    SEL_CLK  = 3'd0,
    SEL_CFG  = 3'd1,
    SEL_IDX  = 3'd2,
    SEL_ARGH = 3'd3,
    SEL_ARGL = 3'd4
  } reg_sel_e;

  typedef enum logic {ST_IDLE, ST_WAIT} iss_state_e;

  localparam int CFG_DEN_BIT  = 2;
  localparam int CFG_DIR_BIT  = 3;
  localparam int CFG_STOP_BIT = 10;

  // minimum reply bytes demanded by each response type
  function automatic int rsp_need(input logic [1:0] rtype);
    case (rtype)
      2'd0:    rsp_need = 0;
      2'd2:    rsp_need = 16;
      default: rsp_need = 4;
    endcase
  endfunction

  function automatic logic rsp_len_ok(input logic [1:0] rtype, input int nbytes);
    rsp_len_ok = (nbytes >= rsp_need(rtype));
  endfunction

endpackage

// File: rtl/cmdrsp_regs.sv
module cmdrsp_regs
  import cmdrsp_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int HALF_W = 16,
  parameter int CFG_W  = 14,
  parameter logic [CFG_W-1:0] CFG_KEEP = 14'h3dff
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            wr_sel,
  input  logic [HALF_W-1:0]     wr_data,
  input  logic                  launch,
  output logic [IDX_W-1:0]      idx_q,
  output logic [2*HALF_W-1:0]   arg_q,
  output logic [CFG_W-1:0]      cfg_q,
  output logic                  clk_en_q,
  output logic                  pending_q,
  output logic                  start_req,
  output logic                  cfg_wr_evt,
  output logic                  clk_stop_evt
);

  logic clk_wr_evt;
  logic clk_start_evt;

  assign clk_wr_evt    = wr_en && (wr_sel == SEL_CLK);
  assign cfg_wr_evt    = wr_en && (wr_sel == SEL_CFG);
  assign clk_stop_evt  = clk_wr_evt && wr_data[0];
  assign clk_start_evt = clk_wr_evt && wr_data[1] && !wr_data[0];

  assign start_req = (cfg_wr_evt && !wr_data[CFG_STOP_BIT] && clk_en_q)
                   || (clk_start_evt && pending_q && !cfg_q[CFG_STOP_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      arg_q     <= '0;
      cfg_q     <= '0;
      clk_en_q  <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_IDX)  idx_q <= wr_data[IDX_W-1:0];
      if (wr_en && wr_sel == SEL_ARGH) arg_q[2*HALF_W-1:HALF_W] <= wr_data;
      if (wr_en && wr_sel == SEL_ARGL) arg_q[HALF_W-1:0] <= wr_data;
      if (cfg_wr_evt) cfg_q <= wr_data[CFG_W-1:0] & CFG_KEEP;
      if (clk_stop_evt)       clk_en_q <= 1'b0;
      else if (clk_start_evt) clk_en_q <= 1'b1;
      if (launch)          pending_q <= 1'b0;
      else if (cfg_wr_evt) pending_q <= 1'b1;
    end
  end

endmodule

// File: rtl/cmdrsp_fsm.sv
module cmdrsp_fsm
  import cmdrsp_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             cfg_wr_evt,
  input  logic             clk_stop_evt,
  input  logic [1:0]       rtype,
  input  logic             den,
  input  logic             card_done,
  input  logic [LEN_W-1:0] card_len,
  output logic             launch,
  output logic             capture,
  output logic             capture_ok,
  output logic             card_req,
  output logic             stat_tout,
  output logic             stat_rsp_end,
  output logic             eoc_pulse,
  output logic             data_active
);

  iss_state_e state_q;

  assign launch     = (state_q == ST_IDLE) && start_req;
  assign capture    = (state_q == ST_WAIT) && card_done;
  assign capture_ok = rsp_len_ok(rtype, int'(card_len));
  assign card_req   = (state_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      stat_tout    <= 1'b0;
      stat_rsp_end <= 1'b0;
      eoc_pulse    <= 1'b0;
      data_active  <= 1'b0;
    end else begin
      eoc_pulse <= capture;
      if (launch) begin
        state_q      <= ST_WAIT;
        stat_tout    <= 1'b0;
        stat_rsp_end <= 1'b0;
        data_active  <= 1'b0;
      end else if (capture) begin
        state_q <= ST_IDLE;
        if (capture_ok) begin
          stat_rsp_end <= 1'b1;
          data_active  <= den;
        end else begin
          stat_tout <= 1'b1;
        end
      end
      if (cfg_wr_evt || clk_stop_evt) data_active <= 1'b0;
    end
  end

endmodule

// File: rtl/cmdrsp_store.sv
module cmdrsp_store #(
  parameter int RSP_BYTES = 16,
  parameter int RSP_WORDS = 9,
  parameter int LEN_W     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   fill,
  input  logic [LEN_W-1:0]       card_len,
  input  logic [8*RSP_BYTES-1:0] card_bytes,
  input  logic                   pop,
  output logic [15:0]            word
);

  localparam int PTR_W = $clog2(RSP_WORDS + 1);

  logic [RSP_WORDS-1:0][15:0] fill_val;
  logic [RSP_WORDS-1:0][15:0] store_q;
  logic [PTR_W-1:0]           ptr_q;

  for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int BI = 2 * w + h;
      if (BI < RSP_BYTES) begin : g_live
        assign fill_val[w][8*h +: 8] =
          (BI < int'(card_len)) ? card_bytes[8*BI +: 8] : 8'h00;
      end else begin : g_pad
        assign fill_val[w][8*h +: 8] = 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      ptr_q   <= '0;
    end else if (clear) begin
      store_q <= '0;
      ptr_q   <= '0;
    end else if (fill) begin
      store_q <= fill_val;
    end else if (pop && int'(ptr_q) < RSP_WORDS) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign word = (int'(ptr_q) < RSP_WORDS) ? store_q[ptr_q] : 16'h0000;

endmodule

// File: rtl/cmdrsp_top.sv
module cmdrsp_top
  import cmdrsp_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int HALF_W    = 16,
  parameter int CFG_W     = 14,
  parameter int RSP_BYTES = 16,
  parameter int RSP_WORDS = 9,
  localparam int LEN_W    = $clog2(RSP_BYTES + 1),
  localparam int ARG_W    = 2 * HALF_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [2:0]             wr_sel,
  input  logic [HALF_W-1:0]      wr_data,
  output logic [IDX_W:0]         idx_rb,
  output logic [ARG_W-1:0]       arg_rb,
  output logic [CFG_W-1:0]       cfg_rb,
  input  logic                   rsp_pop,
  output logic [15:0]            rsp_word,
  output logic                   card_req,
  output logic [IDX_W-1:0]       card_idx,
  output logic [ARG_W-1:0]       card_arg,
  input  logic                   card_done,
  input  logic [LEN_W-1:0]       card_len,
  input  logic [8*RSP_BYTES-1:0] card_bytes,
  output logic                   stat_clk_en,
  output logic                   stat_tout,
  output logic                   stat_rsp_end,
  output logic                   eoc_pulse,
  output logic                   data_active,
  output logic                   data_write
);

  logic [IDX_W-1:0] idx_q;
  logic [ARG_W-1:0] arg_q;
  logic [CFG_W-1:0] cfg_q;
  logic pending_q, start_req, cfg_wr_evt, clk_stop_evt;
  logic launch, capture, capture_ok;

  cmdrsp_regs #(.IDX_W(IDX_W), .HALF_W(HALF_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .launch(launch), .idx_q(idx_q), .arg_q(arg_q), .cfg_q(cfg_q),
    .clk_en_q(stat_clk_en), .pending_q(pending_q), .start_req(start_req),
    .cfg_wr_evt(cfg_wr_evt), .clk_stop_evt(clk_stop_evt)
  );

  cmdrsp_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg_wr_evt(cfg_wr_evt),
    .clk_stop_evt(clk_stop_evt), .rtype(cfg_q[1:0]), .den(cfg_q[CFG_DEN_BIT]),
    .card_done(card_done), .card_len(card_len), .launch(launch),
    .capture(capture), .capture_ok(capture_ok), .card_req(card_req),
    .stat_tout(stat_tout), .stat_rsp_end(stat_rsp_end),
    .eoc_pulse(eoc_pulse), .data_active(data_active)
  );

  cmdrsp_store #(.RSP_BYTES(RSP_BYTES), .RSP_WORDS(RSP_WORDS), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(launch), .fill(capture && capture_ok),
    .card_len(card_len), .card_bytes(card_bytes), .pop(rsp_pop), .word(rsp_word)
  );

  assign idx_rb     = {1'b1, idx_q};
  assign arg_rb     = arg_q;
  assign cfg_rb     = cfg_q;
  assign card_idx   = idx_q;
  assign card_arg   = arg_q;
  assign data_write = cfg_q[CFG_DIR_BIT];

endmodule

// File: rtl/cmdrsp_chk.sv
module cmdrsp_chk #(
  parameter int IDX_RB_W = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                card_req,
  input logic                card_done,
  input logic                eoc_pulse,
  input logic                stat_tout,
  input logic                stat_rsp_end,
  input logic                data_active,
  input logic                stat_clk_en,
  input logic                clk_stop_evt,
  input logic [IDX_RB_W-1:0] idx_rb
);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_req && !card_done) |=> card_req);

  // R8
  eoc_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |-> $past(card_req && card_done));

  // R6
  tout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_tout && stat_rsp_end));

  // R7
  data_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_active |-> stat_rsp_end);

  // R2
  idx_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rb[IDX_RB_W-1]);

  // R4
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop_evt |=> !stat_clk_en);

endmodule

bind cmdrsp_top cmdrsp_chk #(.IDX_RB_W(IDX_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .card_req(card_req), .card_done(card_done),
  .eoc_pulse(eoc_pulse), .stat_tout(stat_tout), .stat_rsp_end(stat_rsp_end),
  .data_active(data_active), .stat_clk_en(stat_clk_en),
  .clk_stop_evt(clk_stop_evt), .idx_rb(idx_rb)
);

// File: tb/cmdrsp_top_tb.sv
module cmdrsp_top_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_sel = 3'd0;
  logic [15:0]  wr_data = 16'h0;
  logic [6:0]   idx_rb;
  logic [31:0]  arg_rb;
  logic [13:0]  cfg_rb;
  logic         rsp_pop = 1'b0;
  logic [15:0]  rsp_word;
  logic         card_req;
  logic [5:0]   card_idx;
  logic [31:0]  card_arg;
  logic         card_done = 1'b0;
  logic [4:0]   card_len = 5'd0;
  logic [127:0] card_bytes = '0;
  logic         stat_clk_en, stat_tout, stat_rsp_end, eoc_pulse, data_active, data_write;

  int checks = 0;
  int errs = 0;

  always #2 clk = ~clk;

  cmdrsp_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .idx_rb(idx_rb), .arg_rb(arg_rb), .cfg_rb(cfg_rb), .rsp_pop(rsp_pop),
    .rsp_word(rsp_word), .card_req(card_req), .card_idx(card_idx),
    .card_arg(card_arg), .card_done(card_done), .card_len(card_len),
    .card_bytes(card_bytes), .stat_clk_en(stat_clk_en), .stat_tout(stat_tout),
    .stat_rsp_end(stat_rsp_end), .eoc_pulse(eoc_pulse),
    .data_active(data_active), .data_write(data_write)
  );

  typedef struct packed {
    logic [1:0] rtype;
    logic [4:0] len;
    logic       den;
    logic       dir;
    logic       e_tout;
    logic       e_end;
    logic       e_act;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd1, 5'd6,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd1, 5'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'd2, 5'd16, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{2'd2, 5'd15, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'd3, 5'd4,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{2'd3, 5'd2,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{2'd1, 5'd4,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    rsp_pop = 1'b1;
    @(negedge clk);
    rsp_pop = 1'b0;
  endtask

  // answer an outstanding request; byte k = seed + k for all 16 bytes
  task automatic respond(input logic [4:0] len, input logic [7:0] seed);
    int waited = 0;
    while (!card_req && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    chk("R5 request seen", 32'(card_req), 32'd1);
    for (int k = 0; k < 16; k++) card_bytes[8*k +: 8] = seed + 8'(k);
    card_len = len;
    card_done = 1'b1;
    @(negedge clk);
    card_done = 1'b0;
  endtask

  function automatic logic [15:0] exp_word(input int w, input int len, input logic [7:0] seed,
                                           input logic good);
    logic [7:0] lo, hi;
    lo = (2*w < len) ? seed + 8'(2*w) : 8'h00;
    hi = (2*w + 1 < len) ? seed + 8'(2*w + 1) : 8'h00;
    if (!good || w >= 8) return 16'h0000;
    return {hi, lo};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 clk_en", 32'(stat_clk_en), 0);
    chk("R1 tout", 32'(stat_tout), 0);
    chk("R1 rsp_end", 32'(stat_rsp_end), 0);
    chk("R1 req", 32'(card_req), 0);
    chk("R1 data_active", 32'(data_active), 0);
    chk("R1 eoc", 32'(eoc_pulse), 0);
    chk("R1 word", 32'(rsp_word), 0);
    chk("R1 idx_rb", 32'(idx_rb), 32'h40);
    chk("R1 arg_rb", arg_rb, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 registers
    wr(3'd2, 16'h002a);
    wr(3'd3, 16'hdead);
    wr(3'd4, 16'hbeef);
    chk("R2 idx_rb", 32'(idx_rb), 32'h6a);
    chk("R2 arg_rb", arg_rb, 32'hdeadbeef);
    wr(3'd4, 16'h1234);
    chk("R2 low half only", arg_rb, 32'hdead1234);

    // R3 config with clock stopped: pending, no start
    wr(3'd1, 16'h0001);
    chk("R3 no start clock off", 32'(card_req), 0);
    // R4 clock start launches pending command
    wr(3'd0, 16'h0002);
    chk("R4 clk_en", 32'(stat_clk_en), 1);
    chk("R4 start pending", 32'(card_req), 1);
    chk("R2 card_idx", 32'(card_idx), 32'h2a);
    chk("R2 card_arg", card_arg, 32'hdead1234);
    respond(5'd4, 8'h10);
    chk("R8 eoc", 32'(eoc_pulse), 1);
    chk("R5 req dropped", 32'(card_req), 0);
    chk("R7 rsp_end", 32'(stat_rsp_end), 1);
    @(negedge clk);
    chk("R8 eoc one cycle", 32'(eoc_pulse), 0);
    // R5 pending cleared: a second clock start does not relaunch
    wr(3'd0, 16'h0002);
    chk("R5 pending cleared", 32'(card_req), 0);

    // table of response types against lengths
    for (int v = 0; v < NVEC; v++) begin
      automatic vec_t t = VECS[v];
      automatic logic [7:0] seed = 8'(8'h30 + 8'(v * 16));
      wr(3'd1, {12'h0, t.dir, t.den, t.rtype});
      chk($sformatf("R3 immediate start v%0d", v), 32'(card_req), 1);
      chk($sformatf("R11 status cleared v%0d", v), 32'({stat_tout, stat_rsp_end}), 0);
      respond(t.len, seed);
      chk($sformatf("R6 tout v%0d", v), 32'(stat_tout), 32'(t.e_tout));
      chk($sformatf("R7 rsp_end v%0d", v), 32'(stat_rsp_end), 32'(t.e_end));
      chk($sformatf("R7 data_active v%0d", v), 32'(data_active), 32'(t.e_act));
      chk($sformatf("R7 data_write v%0d", v), 32'(data_write), 32'(t.dir));
      chk($sformatf("R8 eoc v%0d", v), 32'(eoc_pulse), 1);
      for (int w = 0; w < 9; w++) begin
        chk($sformatf("R9 word v%0d w%0d", v, w), 32'(rsp_word),
            32'(exp_word(w, int'(t.len), seed, t.e_end)));
        pop();
      end
      chk($sformatf("R10 exhausted v%0d", v), 32'(rsp_word), 0);
      pop();
      chk($sformatf("R10 stays zero v%0d", v), 32'(rsp_word), 0);
    end

    // last vector left a data phase active; config write with stop bit cancels it
    chk("R7 data phase before cancel", 32'(data_active), 1);
    wr(3'd1, 16'hffff);
    chk("R3 mask", 32'(cfg_rb), 32'h3dff);
    chk("R3 cancel", 32'(data_active), 0);
    chk("R3 stop bit no start", 32'(card_req), 0);
    wr(3'd0, 16'h0002);
    chk("R4 stop bit blocks clock start", 32'(card_req), 0);

    // R3 new config launches with clock running
    wr(3'd1, 16'h0000);
    chk("R3 start", 32'(card_req), 1);
    respond(5'd0, 8'h00);
    chk("R6 type0 ok", 32'(stat_rsp_end), 1);

    // R4 both bits: stop wins
    wr(3'd0, 16'h0003);
    chk("R4 stop priority", 32'(stat_clk_en), 0);
    wr(3'd1, 16'h0001);
    chk("R3 clock off no start", 32'(card_req), 0);
    chk("R11 status held before start", 32'(stat_rsp_end), 1);
    wr(3'd0, 16'h0002);
    chk("R4 deferred start", 32'(card_req), 1);
    chk("R11 start clears rsp_end", 32'(stat_rsp_end), 0);
    respond(5'd8, 8'ha0);
    chk("R9 first word", 32'(rsp_word), 32'ha1a0);
    // R4 clock stop cancels data phase
    wr(3'd1, 16'h0005);
    respond(5'd4, 8'h00);
    chk("R7 data phase", 32'(data_active), 1);
    wr(3'd0, 16'h0001);
    chk("R4 stop cancels data", 32'(data_active), 0);
    chk("R4 clk off", 32'(stat_clk_en), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule